// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the strobes that pace a raster LCD panel. It gives horizontal and vertical sync, a data-enable window and a pixel clock enable taken from an integer divider of the logic clock. It also drives an AC-bias toggle for passive panels, a single-cycle frame-start strobe and a programmable line-compare strobe. A host configures it through a write-only port with four 32-bit registers. A controller that fetches pixel data uses the strobes to know when to supply each pixel.

Each line walks through the horizontal phases `H_SYNC -> H_BACK -> H_ACT -> H_FRONT -> H_SYNC`. A phase advances only on a pixel tick, and only once its pixel count is used up. `H_IDLE` is held while the generator is disabled and left for `H_SYNC` on the first enabled cycle. At each line end the vertical state steps through `V_SYNC -> V_BACK -> V_ACT -> V_FRONT -> V_SYNC`. When its porch count is zero, `V_BACK` is skipped (`V_SYNC -> V_ACT`), and likewise `V_FRONT` (`V_ACT -> V_SYNC`). Disabling forces `H_IDLE`/`V_SYNC`.

Register writes land in a shadow copy. The working copy follows the shadow only while the generator is disabled, so each run uses one frozen timing set from its first frame on.

Top module: `lcd_raster_timer`

## Requirements
- R1: Register 0 gives active pixels minus one in [9:0], horizontal sync width minus one in [15:10], front porch minus one in [23:16] and back porch minus one in [31:24], all counted in pixel ticks. Each line is sync, back porch, active, front porch.
- R2: Register 1 gives active lines minus one in [9:0] and vertical sync lines minus one in [15:10]. The vertical front porch in [23:16] and back porch in [31:24] are line counts taken as written, and zero removes that phase.
- R3: Register 2 [7:0] is the divisor. `pix_ce` pulses once every divisor clock cycles. A divisor below 2 with `panel_tft`=1, or below 3 with `panel_tft`=0, is raised to that minimum, and 255 is accepted.
- R4: Register 2 bit 20 inverts `vsync`, bit 21 inverts `hsync` and bit 23 inverts `de`. Bit 22 appears on `pix_edge_sel`. While disabled, each sync and `de` rests at its polarity bit.
- R5: Register 2 [15:8] is the AC-bias line count. `ac_bias` toggles each time that many lines have completed, and a count of zero holds it low.
- R6: Register 3 [9:0] selects an active line number, counted from 0 at the first active line. `line_strobe` is high for the one pixel tick that starts that line, and never when the number is not below the active line count.
- R7: `frame_strobe` is high for one cycle per frame, on the pixel tick of the first active pixel of active line 0, together with `pix_ce` and active `de`.
- R8: Writes made while `enable` is high do not change the running timing. They apply from the next enable.
- R9: After reset, and whenever `enable` is low, there are no pixel ticks or strobes, `ac_bias` is low and syncs and `de` are inactive.
- R10: Horizontal sync and the data-enable window are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the generator; low idles it and lets new timing load |
| panel_tft | input | 1 | 1 for active-matrix panel (divisor minimum 2), 0 for passive (minimum 3) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select 0..3 |
| cfg_wdata | input | 32 | Register write data |
| pix_ce | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pix_edge_sel | output | 1 | Pixel clock edge select bit |
| ac_bias | output | 1 | AC-bias toggle |
| frame_strobe | output | 1 | First active pixel of each frame |
| line_strobe | output | 1 | Start of the compared active line |

## Verification
On every cycle the assertions check the following:
- no pixel tick while disabled;
- no two ticks back to back;
- the frame and line strobes land on ticks;
- the frame strobe lands inside active data, and never twice in a row;
- sync and data enable stay apart;
- a zero AC-bias count keeps the toggle low.

Only the bench scenarios can show the following:
- the per-frame totals that follow from the field encodings and the divisor clamp;
- where the line strobe lands and whether it appears at all;
- the AC-bias interval in lines;
- that writes made mid-run are deferred until the next enable.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 2;
    localparam int PIX_W    = 10;
    localparam int SYNC_W   = 6;
    localparam int PORCH_W  = 8;
    localparam int LINE_W   = 10;
    localparam int DIV_W    = 8;
    localparam int ACB_W    = 8;

    typedef enum logic [2:0] {
        H_IDLE, H_SYNC, H_BACK, H_ACT, H_FRONT
    } hphase_e;

    typedef enum logic [1:0] {
        V_SYNC, V_BACK, V_ACT, V_FRONT
    } vphase_e;

    typedef struct packed {
        logic [PIX_W-1:0]   ppl_m1;
        logic [SYNC_W-1:0]  hsw_m1;
        logic [PORCH_W-1:0] hfp_m1;
        logic [PORCH_W-1:0] hbp_m1;
        logic [LINE_W-1:0]  lpp_m1;
        logic [SYNC_W-1:0]  vsw_m1;
        logic [PORCH_W-1:0] vfp;
        logic [PORCH_W-1:0] vbp;
        logic [DIV_W-1:0]   div;
        logic [ACB_W-1:0]   acb;
        logic               inv_vs;
        logic               inv_hs;
        logic               edge_sel;
        logic               inv_de;
        logic [LINE_W-1:0]  line_cmp;
    } tcfg_t;
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs import lcd_tg_pkg::*; #(
    parameter int MIN_DIV_TFT     = 2,
    parameter int MIN_DIV_PASSIVE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              panel_tft,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output tcfg_t             cfg
);
    localparam logic [DIV_W-1:0] MIN_T = DIV_W'(MIN_DIV_TFT);
    localparam logic [DIV_W-1:0] MIN_P = DIV_W'(MIN_DIV_PASSIVE);

    tcfg_t            shd;
    logic [DIV_W-1:0] div_min;
    logic [DIV_W-1:0] div_eff;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd <= '0;
        end else if (we) begin
            unique case (addr)
                2'd0: begin
                    shd.ppl_m1 <= wdata[9:0];
                    shd.hsw_m1 <= wdata[15:10];
                    shd.hfp_m1 <= wdata[23:16];
                    shd.hbp_m1 <= wdata[31:24];
                end
                2'd1: begin
                    shd.lpp_m1 <= wdata[9:0];
                    shd.vsw_m1 <= wdata[15:10];
                    shd.vfp    <= wdata[23:16];
                    shd.vbp    <= wdata[31:24];
                end
                2'd2: begin
                    shd.div      <= wdata[7:0];
                    shd.acb      <= wdata[15:8];
                    shd.inv_vs   <= wdata[20];
                    shd.inv_hs   <= wdata[21];
                    shd.edge_sel <= wdata[22];
                    shd.inv_de   <= wdata[23];
                end
                2'd3: begin
                    shd.line_cmp <= wdata[9:0];
                end
            endcase
        end
    end

    assign div_min = panel_tft ? MIN_T : MIN_P;
    assign div_eff = (shd.div < div_min) ? div_min : shd.div;

    // working copy only follows the shadow while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '0;
            cfg.div <= MIN_P;
        end else if (!run) begin
            cfg     <= shd;
            cfg.div <= div_eff;
        end
    end
endmodule

// File: rtl/lcd_tg_clkdiv.sv
module lcd_tg_clkdiv #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt == div - DW'(1));
    assign tick   = run && at_end;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || at_end)
            cnt <= '0;
        else
            cnt <= cnt + DW'(1);
    end
endmodule

// File: rtl/lcd_tg_seq.sv
module lcd_tg_seq import lcd_tg_pkg::*; (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  tick,
    input  tcfg_t cfg,
    output logic  hs_raw,
    output logic  vs_raw,
    output logic  de_raw,
    output logic  frame_pulse,
    output logic  line_pulse,
    output logic  line_done
);
    hphase_e           hst, hst_n;
    vphase_e           vst, vst_n;
    logic [PIX_W-1:0]  hcnt, hcnt_n, h_lim;
    logic [LINE_W-1:0] vcnt, vcnt_n;
    logic              v_last;
    logic              line_end;

    always_comb begin
        unique case (hst)
            H_SYNC:  h_lim = PIX_W'(cfg.hsw_m1);
            H_BACK:  h_lim = PIX_W'(cfg.hbp_m1);
            H_ACT:   h_lim = cfg.ppl_m1;
            H_FRONT: h_lim = PIX_W'(cfg.hfp_m1);
            default: h_lim = '0;
        endcase
    end

    always_comb begin
        unique case (vst)
            V_SYNC:  v_last = (vcnt == LINE_W'(cfg.vsw_m1));
            V_BACK:  v_last = ((vcnt + LINE_W'(1)) == LINE_W'(cfg.vbp));
            V_ACT:   v_last = (vcnt == cfg.lpp_m1);
            V_FRONT: v_last = ((vcnt + LINE_W'(1)) == LINE_W'(cfg.vfp));
            default: v_last = 1'b1;
        endcase
    end

    // next-state logic
    always_comb begin
        hst_n    = hst;
        hcnt_n   = hcnt;
        vst_n    = vst;
        vcnt_n   = vcnt;
        line_end = 1'b0;
        if (!run) begin
            hst_n  = H_IDLE;
            hcnt_n = '0;
            vst_n  = V_SYNC;
            vcnt_n = '0;
        end else if (hst == H_IDLE) begin
            hst_n = H_SYNC;
        end else if (tick) begin
            if (hcnt == h_lim) begin
                hcnt_n = '0;
                unique case (hst)
                    H_SYNC:  hst_n = H_BACK;
                    H_BACK:  hst_n = H_ACT;
                    H_ACT:   hst_n = H_FRONT;
                    H_FRONT: begin
                        hst_n    = H_SYNC;
                        line_end = 1'b1;
                    end
                    default: hst_n = H_IDLE;
                endcase
            end else begin
                hcnt_n = hcnt + PIX_W'(1);
            end
        end
        if (line_end) begin
            if (v_last) begin
                vcnt_n = '0;
                unique case (vst)
                    V_SYNC:  vst_n = (cfg.vbp != '0) ? V_BACK : V_ACT;
                    V_BACK:  vst_n = V_ACT;
                    V_ACT:   vst_n = (cfg.vfp != '0) ? V_FRONT : V_SYNC;
                    V_FRONT: vst_n = V_SYNC;
                    default: vst_n = V_SYNC;
                endcase
            end else begin
                vcnt_n = vcnt + LINE_W'(1);
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hst  <= H_IDLE;
            hcnt <= '0;
            vst  <= V_SYNC;
            vcnt <= '0;
        end else begin
            hst  <= hst_n;
            hcnt <= hcnt_n;
            vst  <= vst_n;
            vcnt <= vcnt_n;
        end
    end

    // outputs
    always_comb begin
        hs_raw      = run && (hst == H_SYNC);
        vs_raw      = run && (hst != H_IDLE) && (vst == V_SYNC);
        de_raw      = run && (hst == H_ACT) && (vst == V_ACT);
        frame_pulse = tick && de_raw && (hcnt == '0) && (vcnt == '0);
        line_pulse  = tick && (hst == H_SYNC) && (hcnt == '0) &&
                      (vst == V_ACT) && (vcnt == cfg.line_cmp);
        line_done   = line_end;
    end
endmodule

// File: rtl/lcd_tg_acbias.sv
module lcd_tg_acbias #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          line_done,
    input  logic [CW-1:0] count,
    output logic          ac
);
    logic [CW-1:0] seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
            ac   <= 1'b0;
        end else if (!run || count == '0) begin
            seen <= '0;
            ac   <= 1'b0;
        end else if (line_done) begin
            if (seen + CW'(1) == count) begin
                seen <= '0;
                ac   <= ~ac;
            end else begin
                seen <= seen + CW'(1);
            end
        end
    end
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer import lcd_tg_pkg::*; #(
    parameter int MIN_DIV_TFT     = 2,
    parameter int MIN_DIV_PASSIVE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              panel_tft,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic              pix_ce,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              pix_edge_sel,
    output logic              ac_bias,
    output logic              frame_strobe,
    output logic              line_strobe
);
    tcfg_t act_cfg;
    logic  tick;
    logic  hs_raw, vs_raw, de_raw;
    logic  line_done;
    logic  acb_zero;

    lcd_tg_regs #(
        .MIN_DIV_TFT    (MIN_DIV_TFT),
        .MIN_DIV_PASSIVE(MIN_DIV_PASSIVE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .panel_tft(panel_tft),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .cfg      (act_cfg)
    );

    lcd_tg_clkdiv #(.DW(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (enable),
        .div  (act_cfg.div),
        .tick (tick)
    );

    lcd_tg_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enable),
        .tick       (tick),
        .cfg        (act_cfg),
        .hs_raw     (hs_raw),
        .vs_raw     (vs_raw),
        .de_raw     (de_raw),
        .frame_pulse(frame_strobe),
        .line_pulse (line_strobe),
        .line_done  (line_done)
    );

    lcd_tg_acbias #(.CW(ACB_W)) u_acb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .line_done(line_done),
        .count    (act_cfg.acb),
        .ac       (ac_bias)
    );

    assign pix_ce       = tick;
    assign hsync        = hs_raw ^ act_cfg.inv_hs;
    assign vsync        = vs_raw ^ act_cfg.inv_vs;
    assign de           = de_raw ^ act_cfg.inv_de;
    assign pix_edge_sel = act_cfg.edge_sel;
    assign acb_zero     = (act_cfg.acb == '0);
endmodule

// File: rtl/lcd_tg_checker.sv
module lcd_tg_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic pix_ce,
    input logic frame_strobe,
    input logic line_strobe,
    input logic hs_raw,
    input logic de_raw,
    input logic ac_bias,
    input logic acb_zero
);
    assert_idle_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!pix_ce && !frame_strobe && !line_strobe));

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce |=> !pix_ce);

    assert_frame_on_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |-> (pix_ce && de_raw));

    assert_frame_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> !frame_strobe);

    assert_line_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_strobe |-> pix_ce);

    assert_sync_data_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_raw && de_raw));

    assert_acb_zero_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acb_zero && !ac_bias) |=> !ac_bias);
endmodule

bind lcd_raster_timer lcd_tg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .pix_ce      (pix_ce),
    .frame_strobe(frame_strobe),
    .line_strobe (line_strobe),
    .hs_raw      (hs_raw),
    .de_raw      (de_raw),
    .ac_bias     (ac_bias),
    .acb_zero    (acb_zero)
);

// File: tb/sim_lcd_raster_timer.sv
`timescale 1ns/1ps
module sim_lcd_raster_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        panel_tft = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic pix_ce, hsync, vsync, de, pix_edge_sel, ac_bias, frame_strobe, line_strobe;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_raster_timer u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .panel_tft(panel_tft),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_edge_sel(pix_edge_sel), .ac_bias(ac_bias),
        .frame_strobe(frame_strobe), .line_strobe(line_strobe)
    );

    typedef struct {
        int cyc; int de_t; int hs_t; int vs_t; int ls; int acz;
    } item_t;
    item_t exp_q[$];

    int total = 0;
    int bad   = 0;

    // bench copy of the programmed timing
    int c_ppl, c_hsw, c_hfp, c_hbp, c_lpp, c_vsw, c_vfp, c_vbp;
    int c_div, c_acb, c_cmp;
    bit c_tft, c_ivv, c_ivh, c_edge, c_ide;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic write_reg(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] t0_word(input int ppl, input int hsw,
                                            input int hfp, input int hbp);
        return {8'(hbp), 8'(hfp), 6'(hsw), 10'(ppl)};
    endfunction

    task automatic set_cfg(input bit tft, input int ppl, input int hsw, input int hfp,
                           input int hbp, input int lpp, input int vsw, input int vfp,
                           input int vbp, input int dv, input int acb, input int cmp,
                           input bit ivv, input bit ivh, input bit edg, input bit ide);
        logic [31:0] t2;
        c_tft = tft; c_ppl = ppl; c_hsw = hsw; c_hfp = hfp; c_hbp = hbp;
        c_lpp = lpp; c_vsw = vsw; c_vfp = vfp; c_vbp = vbp; c_div = dv;
        c_acb = acb; c_cmp = cmp; c_ivv = ivv; c_ivh = ivh; c_edge = edg; c_ide = ide;
        panel_tft = tft;
        write_reg(0, t0_word(ppl, hsw, hfp, hbp));
        write_reg(1, {8'(vbp), 8'(vfp), 6'(vsw), 10'(lpp)});
        t2 = {6'b0, 2'b11, ide, edg, ivh, ivv, 4'b0, 8'(acb), 8'(dv)};
        write_reg(2, t2);
        write_reg(3, 32'(cmp));
        repeat (3) @(posedge clk);
    endtask

    // driver: push expected frame windows, run, then stop
    task automatic run_windows(input int nwin, input int mid_ppl);
        int mind, deff, tl, nl;
        item_t it;
        mind = c_tft ? 2 : 3;
        deff = (c_div < mind) ? mind : c_div;
        tl = (c_hsw + 1) + (c_hbp + 1) + (c_ppl + 1) + (c_hfp + 1);
        nl = (c_vsw + 1) + c_vbp + (c_lpp + 1) + c_vfp;
        it.cyc  = deff * tl * nl;
        it.de_t = (c_ppl + 1) * (c_lpp + 1);
        it.hs_t = (c_hsw + 1) * nl;
        it.vs_t = (c_vsw + 1) * tl;
        it.ls   = (c_cmp <= c_lpp) ? 1 : 0;
        it.acz  = (c_acb == 0) ? 1 : 0;
        for (int i = 0; i < nwin; i++) exp_q.push_back(it);
        @(posedge clk); #1;
        enable = 1'b1;
        if (mid_ppl >= 0) begin
            repeat (40) @(posedge clk);
            #1;
            cfg_we = 1'b1; cfg_addr = 2'd0;
            cfg_wdata = t0_word(mid_ppl, c_hsw, c_hfp, c_hbp);
            @(posedge clk); #1;
            cfg_we = 1'b0;
        end
        while (exp_q.size() != 0) @(posedge clk);
        #1;
        enable = 1'b0;
        if (mid_ppl >= 0) c_ppl = mid_ppl;
        repeat (3) @(negedge clk);
        chk(pix_ce == 1'b0, "R9", "pix_ce after disable", int'(pix_ce), 0);
        chk(hsync == c_ivh, "R9", "hsync idle level", int'(hsync), int'(c_ivh));
    endtask

    // monitor / scoreboard
    bit win_open = 0, ac_prev = 0, hs_prev = 0;
    int ac_lines = 0;
    int w_cyc, w_de, w_hs, w_vs, w_ls, w_tog;
    initial begin
        bit hs_a, vs_a, de_a;
        item_t it;
        forever begin
            @(negedge clk);
            hs_a = hsync ^ c_ivh;
            vs_a = vsync ^ c_ivv;
            de_a = de ^ c_ide;
            if (!rst_n || !enable) begin
                win_open = 0; ac_prev = 0; hs_prev = 0; ac_lines = 0;
            end else begin
                if (ac_bias != ac_prev) begin
                    w_tog++;
                    if (c_acb != 0)
                        chk(ac_lines == c_acb, "R5", "lines between ac toggles",
                            ac_lines, c_acb);
                    ac_lines = 0;
                end
                if (hs_a && !hs_prev) ac_lines++;
                ac_prev = ac_bias;
                hs_prev = hs_a;
                if (frame_strobe) begin
                    chk(pix_ce && de_a, "R7", "frame strobe on active tick",
                        int'(pix_ce && de_a), 1);
                    if (win_open && exp_q.size() > 0) begin
                        it = exp_q.pop_front();
                        chk(w_cyc == it.cyc, "R3", "cycles per frame", w_cyc, it.cyc);
                        chk(w_de == it.de_t, "R1", "active ticks per frame", w_de, it.de_t);
                        chk(w_hs == it.hs_t, "R1", "hsync ticks per frame", w_hs, it.hs_t);
                        chk(w_vs == it.vs_t, "R2", "vsync ticks per frame", w_vs, it.vs_t);
                        chk(w_ls == it.ls, "R6", "line strobes per frame", w_ls, it.ls);
                        if (it.acz == 1)
                            chk(w_tog == 0, "R5", "ac toggles with zero count", w_tog, 0);
                    end
                    win_open = 1;
                    w_cyc = 0; w_de = 0; w_hs = 0; w_vs = 0; w_ls = 0; w_tog = 0;
                end
                w_cyc++;
                if (pix_ce) begin
                    if (de_a) w_de++;
                    if (hs_a) w_hs++;
                    if (vs_a) w_vs++;
                end
                if (line_strobe) w_ls++;
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=finish", WATCHDOG);
        finish_run();
    end

    initial begin
        c_ivv = 0; c_ivh = 0; c_ide = 0; c_acb = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(pix_ce == 0, "R9", "reset pix_ce", int'(pix_ce), 0);
        chk(hsync == 0 && vsync == 0 && de == 0, "R9", "reset syncs/de",
            int'({hsync, vsync, de}), 0);
        chk(ac_bias == 0 && frame_strobe == 0 && line_strobe == 0, "R9",
            "reset strobes", int'({ac_bias, frame_strobe, line_strobe}), 0);

        // A: active-matrix, divisor 2, both vertical porches nonzero
        set_cfg(1, 7, 1, 2, 1, 5, 0, 2, 1, 2, 0, 3, 0, 0, 0, 0);
        run_windows(2, -1);
        // B: passive, divisor 1 raised to 3, zero vertical porches, compare out of range, AC-bias 3
        set_cfg(0, 4, 0, 0, 0, 3, 1, 0, 0, 1, 3, 9, 0, 0, 0, 0);
        run_windows(3, -1);
        // C: active-matrix, divisor 0 raised to 2, compare line 0, AC-bias 2
        set_cfg(1, 9, 2, 1, 3, 2, 2, 3, 2, 0, 2, 0, 0, 0, 0, 0);
        run_windows(2, -1);
        // G: passive with divisor 2 raised to 3 (R3 boundary)
        set_cfg(0, 7, 1, 2, 1, 5, 0, 2, 1, 2, 0, 5, 0, 0, 0, 0);
        run_windows(2, -1);
        // D: R4 polarity, all inversions set
        set_cfg(0, 7, 1, 2, 1, 5, 0, 2, 1, 5, 0, 2, 1, 1, 1, 1);
        chk(hsync == 1, "R4", "inverted hsync idle", int'(hsync), 1);
        chk(vsync == 1, "R4", "inverted vsync idle", int'(vsync), 1);
        chk(de == 1, "R4", "inverted de idle", int'(de), 1);
        chk(pix_edge_sel == 1, "R4", "edge select bit", int'(pix_edge_sel), 1);
        run_windows(2, -1);
        // F: largest divisor
        set_cfg(1, 4, 0, 0, 0, 3, 1, 0, 0, 255, 0, 1, 0, 0, 0, 0);
        run_windows(2, -1);
        // E: R8 write while running is deferred
        set_cfg(1, 7, 1, 2, 1, 5, 0, 2, 1, 2, 0, 3, 0, 0, 0, 0);
        run_windows(2, 11);
        run_windows(2, -1);
        finish_run();
    end
endmodule